// File: doc/BRIEF.md
# Queued-Sample Pulse-Width Modulator

This block produces one pulse-width-modulated output from duty values that software queues in a four-entry FIFO. A small register bus gives access to control, status, sample and period registers. Each write to the sample register appends a duty value to the queue. At the start of each PWM period the modulator takes the oldest queued value. A writer that finds the queue full therefore frees a slot by waiting one period. A self-clearing soft reset empties the queue and returns the registers to their reset values.

Counting runs on a prescaled version of one of two tick inputs, chosen by a field in control. A 12-bit prescaler divides that tick by 1 to 4096. The period counter runs from zero up to the period register value plus one, so one period lasts the register value plus two prescaled ticks. The output is active while the counter is below the current sample, and an inversion bit flips the final level. Three request inputs represent the chip's doze, wait and debug states. Each one freezes the counter unless its matching run bit in control is set.

The controller has three states. In Idle, enable is low and the counter is held at zero. In Run, the modulator counts. In Reset, the soft reset is in progress. The named transitions are:
- enable-rise: Idle to Run. The first queued sample is loaded.
- enable-fall: Run to Idle.
- reset-request: Idle or Run to Reset, on a control write with bit 3 set.
- reset-done: Reset to Idle, after `SWR_LEN` clocks.

Top module: `pwm_sample_gen`

## Requirements
- R1: Registers sit at byte offsets 0x00 (control), 0x04 (status), 0x0C (sample) and 0x10 (period). Control bit 0 is enable, bits [15:4] are the prescaler, bits [17:16] are the clock select, bit 18 is inversion, and bits 22, 23 and 24 are the debug, wait and doze run enables. Every other control bit reads 0. Period reads back bits [15:0] as written. Sample reads back the sample currently in use.
- R2: The queue holds four 16-bit samples. Status bits [2:0] give the number of filled entries, from 0 to 4.
- R3: On enable-rise, the oldest queued sample becomes the current sample. After that, one entry is taken at each completed period while running.
- R4: If the queue is empty at a period boundary, the current sample is kept and used again.
- R5: A sample write while four entries are filled is dropped and sets status bit 4. Bit 4 stays set until a soft reset.
- R6: Writing control with bit 3 set enters Reset. This empties the queue and clears control, period, the current sample and the status overflow flag. Control bit 3 reads 1 for `SWR_LEN` clocks and then clears by itself. Register writes during Reset are ignored.
- R7: The period counter advances once every prescaler field + 1 selected ticks.
- R8: Clock select 01 counts on `tick_bus`, and 10 counts on `tick_fast`. Values 00 and 11 stop counting.
- R9: One period lasts the period register value + 2 prescaled ticks.
- R10: The output is active (1 before inversion) from the start of a period while the counter is below the current sample, and inactive for the rest of the period. Control bit 18 inverts the output.
- R11: While disabled, the counter is held at zero and the output sits at its inactive level, still inverted by bit 18.
- R12: While `doze_req`, `wait_req` or `debug_req` is high and its run enable (bit 24, 23 or 22) is clear, the prescaler and counter hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_bus | input | 1 | Count tick, source 01 |
| tick_fast | input | 1 | Count tick, source 10 |
| doze_req | input | 1 | Doze state active |
| wait_req | input | 1 | Wait state active |
| debug_req | input | 1 | Debug halt active |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench fills the queue and then writes a fifth sample, which must be dropped and must set the overflow flag. A design that dropped the oldest entry instead, or forgot the flag, would show a wrong count or a wrong sample later. It drains the queue until it is empty to check that the last sample is reused, where a faulty design would fall to zero. It also uses samples of 0 and of a value above the period: a comparator with an off-by-one or a wrong period length would show a glitch or a stretched pulse there, and the cycle-accurate model catches either. It checks soft-reset timing, writes ignored during Reset, a clock select that stops counting, and each low-power freeze. A design that kept counting, or that cleared the busy bit early, would diverge from the model on the next clock.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_SWRST} pwm_state_e;

    localparam logic [4:0] A_CTRL = 5'h00;
    localparam logic [4:0] A_STAT = 5'h04;
    localparam logic [4:0] A_SAMP = 5'h0C;
    localparam logic [4:0] A_PER  = 5'h10;

    localparam int B_EN      = 0;
    localparam int B_SWR     = 3;
    localparam int B_PRE_LO  = 4;
    localparam int PRE_W     = 12;
    localparam int B_CSEL_LO = 16;
    localparam int B_INV     = 18;
    localparam int B_DBG     = 22;
    localparam int B_WAIT    = 23;
    localparam int B_DOZE    = 24;
    localparam int B_OVF     = 4;

    localparam logic [1:0] CSEL_BUS  = 2'b01;
    localparam logic [1:0] CSEL_FAST = 2'b10;
endpackage

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     head,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= nxt(wr_ptr);
            if (pop_ok)  rd_ptr <= nxt(rd_ptr);
            if (push_ok && !pop_ok)      level <= level + 1'b1;
            else if (pop_ok && !push_ok) level <= level - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wr_ptr] <= wdata;
    end

    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    // R5
    drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (level == $past(level)));
endmodule

// File: rtl/pwm_period_timer.sv
module pwm_period_timer #(
    parameter int PRE_W = 12,
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [PRE_W-1:0] prescale,
    input  logic [CNT_W-1:0] last,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic [PRE_W-1:0] pre_q;
    logic             pre_hit, at_end;

    assign pre_hit = (pre_q >= prescale);
    assign at_end  = (count >= last);
    assign wrap    = !clear && step && pre_hit && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            count <= '0;
        end else if (clear) begin
            pre_q <= '0;
            count <= '0;
        end else if (step) begin
            if (pre_hit) begin
                pre_q <= '0;
                count <= at_end ? '0 : count + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // R11
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0 && pre_q == '0));

    // R12
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !step) |=> $stable(count));
endmodule

// File: rtl/pwm_sample_gen.sv
module pwm_sample_gen
    import pwm_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int SAMP_W     = 16,
    parameter int SWR_LEN    = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        tick_bus,
    input  logic        tick_fast,
    input  logic        doze_req,
    input  logic        wait_req,
    input  logic        debug_req,
    output logic        pwm_out
);
    localparam int CNT_W = SAMP_W + 1;
    localparam int LVL_W = $clog2(FIFO_DEPTH+1);
    localparam int SWR_W = $clog2(SWR_LEN+1);

    pwm_state_e state_q, state_d;
    logic [SWR_W-1:0]  swr_cnt;
    logic              en_q, inv_q, dbg_en_q, wait_en_q, doze_en_q, ovf_q;
    logic [PRE_W-1:0]  presc_q;
    logic [1:0]        csel_q;
    logic [SAMP_W-1:0] period_q, active_q, fifo_head;
    logic [LVL_W-1:0]  fifo_level;
    logic              fifo_full, fifo_empty;
    logic [CNT_W-1:0]  cnt;
    logic              wrap, tb_clear, tb_step, src_tick, run_ok;
    logic              wr_ctrl, wr_samp, wr_per, swr_req, pop_go, push_ok;
    logic              swr_busy;

    assign wr_ctrl = bus_wr && bus_addr == A_CTRL && state_q != ST_SWRST;
    assign wr_samp = bus_wr && bus_addr == A_SAMP && state_q != ST_SWRST;
    assign wr_per  = bus_wr && bus_addr == A_PER  && state_q != ST_SWRST;
    assign swr_req = wr_ctrl && bus_wdata[B_SWR];
    assign push_ok = wr_samp && !fifo_full;

    always_comb begin
        unique case (csel_q)
            CSEL_BUS:  src_tick = tick_bus;
            CSEL_FAST: src_tick = tick_fast;
            default:   src_tick = 1'b0;
        endcase
    end

    assign run_ok   = !(doze_req && !doze_en_q) && !(wait_req && !wait_en_q)
                      && !(debug_req && !dbg_en_q);
    assign tb_clear = (state_q != ST_RUN) || !en_q || swr_req;
    assign tb_step  = src_tick && run_ok;
    assign pop_go   = !fifo_empty && !swr_req &&
                      ((state_q == ST_IDLE && en_q) || wrap);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (swr_req) state_d = ST_SWRST;
                      else if (en_q) state_d = ST_RUN;
            ST_RUN:   if (swr_req) state_d = ST_SWRST;
                      else if (!en_q) state_d = ST_IDLE;
            ST_SWRST: if (swr_cnt == SWR_W'(SWR_LEN-1)) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            swr_cnt <= '0;
        end else begin
            state_q <= state_d;
            swr_cnt <= (state_q == ST_SWRST) ? swr_cnt + 1'b1 : '0;
        end
    end

    // outputs
    always_comb begin
        swr_busy = (state_q == ST_SWRST);
        pwm_out  = ((state_q == ST_RUN) && (cnt < CNT_W'(active_q))) ^ inv_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0; inv_q <= 1'b0; presc_q <= '0; csel_q <= '0;
            dbg_en_q <= 1'b0; wait_en_q <= 1'b0; doze_en_q <= 1'b0;
            ovf_q <= 1'b0; period_q <= '0; active_q <= '0;
        end else if (swr_req) begin
            en_q <= 1'b0; inv_q <= 1'b0; presc_q <= '0; csel_q <= '0;
            dbg_en_q <= 1'b0; wait_en_q <= 1'b0; doze_en_q <= 1'b0;
            ovf_q <= 1'b0; period_q <= '0; active_q <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q      <= bus_wdata[B_EN];
                presc_q   <= bus_wdata[B_PRE_LO +: PRE_W];
                csel_q    <= bus_wdata[B_CSEL_LO +: 2];
                inv_q     <= bus_wdata[B_INV];
                dbg_en_q  <= bus_wdata[B_DBG];
                wait_en_q <= bus_wdata[B_WAIT];
                doze_en_q <= bus_wdata[B_DOZE];
            end
            if (wr_per) period_q <= bus_wdata[SAMP_W-1:0];
            if (wr_samp && fifo_full) ovf_q <= 1'b1;
            if (pop_go) active_q <= fifo_head;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL: begin
                bus_rdata[B_EN]                 = en_q;
                bus_rdata[B_SWR]                = swr_busy;
                bus_rdata[B_PRE_LO +: PRE_W]    = presc_q;
                bus_rdata[B_CSEL_LO +: 2]       = csel_q;
                bus_rdata[B_INV]                = inv_q;
                bus_rdata[B_DBG]                = dbg_en_q;
                bus_rdata[B_WAIT]               = wait_en_q;
                bus_rdata[B_DOZE]               = doze_en_q;
            end
            A_STAT: begin
                bus_rdata[LVL_W-1:0] = fifo_level;
                bus_rdata[B_OVF]     = ovf_q;
            end
            A_SAMP:  bus_rdata[SAMP_W-1:0] = active_q;
            A_PER:   bus_rdata[SAMP_W-1:0] = period_q;
            default: bus_rdata = '0;
        endcase
    end

    pwm_sample_fifo #(.W(SAMP_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .flush(swr_req), .push(wr_samp),
        .pop(pop_go), .wdata(bus_wdata[SAMP_W-1:0]), .head(fifo_head),
        .level(fifo_level), .full(fifo_full), .empty(fifo_empty)
    );

    pwm_period_timer #(.PRE_W(PRE_W), .CNT_W(CNT_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .clear(tb_clear), .step(tb_step),
        .prescale(presc_q), .last(CNT_W'(period_q) + 1'b1),
        .count(cnt), .wrap(wrap)
    );

    // R6
    swr_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWRST) |-> (fifo_level == '0));

    // R6
    swr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWRST && swr_cnt == SWR_W'(SWR_LEN-1)) |=> (state_q == ST_IDLE));

    // R3
    pop_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !fifo_empty && !push_ok && !swr_req)
        |=> (fifo_level == $past(fifo_level) - LVL_W'(1)));

    // R11
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (pwm_out == inv_q));
endmodule

// File: tb/test_pwm_sample_gen.sv
module test_pwm_sample_gen;
    localparam int SWR_LEN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = 5'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        tick_bus = 1'b1;
    logic        tick_fast = 1'b0;
    logic        doze_req = 1'b0, wait_req = 1'b0, debug_req = 1'b0;
    logic        pwm_out;

    int checks = 0, errors = 0;
    bit running = 0, done = 0;
    string cur_req = "R11";

    pwm_sample_gen #(.SWR_LEN(SWR_LEN)) i_pwm_sample_gen (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_bus(tick_bus),
        .tick_fast(tick_fast), .doze_req(doze_req), .wait_req(wait_req),
        .debug_req(debug_req), .pwm_out(pwm_out)
    );

    always #10 clk = ~clk;
    always @(negedge clk) tick_fast <= ~tick_fast;

    // behavioural reference model
    int m_state, m_t, m_pre, m_cnt, m_per, m_active, m_presc, m_csel;
    bit m_en, m_inv, m_dbg, m_wait, m_doze, m_ovf;
    int mq[$];

    task automatic m_clear();
        mq.delete(); m_en = 0; m_inv = 0; m_dbg = 0; m_wait = 0; m_doze = 0;
        m_ovf = 0; m_per = 0; m_active = 0; m_presc = 0; m_csel = 0;
        m_pre = 0; m_cnt = 0; m_t = 0;
    endtask

    always @(posedge clk) begin : model
        bit full_b, wc, sreq, src, ok;
        if (!rst_n) begin
            m_clear(); m_state = 0;
        end else begin
            full_b = (mq.size() == 4);
            wc     = bus_wr && bus_addr == 5'h00 && m_state != 2;
            sreq   = wc && bus_wdata[3];
            if (m_state == 2) begin
                if (m_t == SWR_LEN-1) begin m_state = 0; m_t = 0; end
                else m_t++;
            end else if (sreq) begin
                m_clear(); m_state = 2;
            end else begin
                if (m_state == 0) begin
                    if (m_en) begin
                        m_state = 1;
                        if (mq.size() > 0) m_active = mq.pop_front();
                    end
                end else if (!m_en) begin
                    m_state = 0; m_cnt = 0; m_pre = 0;
                end else begin
                    src = (m_csel == 1) ? tick_bus : (m_csel == 2) ? tick_fast : 1'b0;
                    ok  = !(doze_req && !m_doze) && !(wait_req && !m_wait) && !(debug_req && !m_dbg);
                    if (src && ok) begin
                        if (m_pre >= m_presc) begin
                            m_pre = 0;
                            if (m_cnt >= m_per + 1) begin
                                m_cnt = 0;
                                if (mq.size() > 0) m_active = mq.pop_front();
                            end else m_cnt++;
                        end else m_pre++;
                    end
                end
                if (wc) begin
                    m_en = bus_wdata[0]; m_presc = int'(bus_wdata[15:4]);
                    m_csel = int'(bus_wdata[17:16]); m_inv = bus_wdata[18];
                    m_dbg = bus_wdata[22]; m_wait = bus_wdata[23]; m_doze = bus_wdata[24];
                end
                if (bus_wr && bus_addr == 5'h0C) begin
                    if (full_b) m_ovf = 1;
                    else mq.push_back(int'(bus_wdata[15:0]));
                end
                if (bus_wr && bus_addr == 5'h10) m_per = int'(bus_wdata[15:0]);
            end
        end
    end

    function automatic logic [31:0] m_rdata(input logic [4:0] a);
        logic [31:0] r = 32'h0;
        case (a)
            5'h00: begin
                r[0] = m_en; r[3] = (m_state == 2); r[15:4] = 12'(m_presc);
                r[17:16] = 2'(m_csel); r[18] = m_inv; r[22] = m_dbg;
                r[23] = m_wait; r[24] = m_doze;
            end
            5'h04: begin r[2:0] = 3'(mq.size()); r[4] = m_ovf; end
            5'h0C: r[15:0] = 16'(m_active);
            5'h10: r[15:0] = 16'(m_per);
            default: r = 32'h0;
        endcase
        return r;
    endfunction

    function automatic logic m_out();
        return ((m_state == 1) && (m_cnt < m_active)) ^ m_inv;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (running && rst_n) check({31'h0, pwm_out}, {31'h0, m_out()}, cur_req);
    end

    function automatic logic [31:0] mk_ctrl(input bit en, input int presc, input int csel,
                                            input bit inv, input bit dbg, input bit wt, input bit dz);
        return {7'h0, dz, wt, dbg, 3'h0, inv, 2'(csel), 12'(presc), 3'h0, en};
    endfunction

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd_lit(input logic [4:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); bus_addr = a; #1; check(bus_rdata, exp, req);
    endtask

    task automatic rd_mod(input logic [4:0] a, input string req);
        @(negedge clk); bus_addr = a; #1; check(bus_rdata, m_rdata(a), req);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin : stim
        int t0, t1;
        bit prev;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        running = 1;
        // R11 reset state
        check({31'h0, pwm_out}, 32'h0, "R11");
        rd_lit(5'h00, 32'h0, "R1");
        rd_lit(5'h04, 32'h0, "R2");
        rd_lit(5'h10, 32'h0, "R1");

        // R2 / R5 fill and overflow
        cur_req = "R2";
        wr(5'h10, 32'h3);
        for (int i = 1; i <= 4; i++) wr(5'h0C, i);
        rd_lit(5'h04, 32'h4, "R2");
        cur_req = "R5";
        wr(5'h0C, 32'h9);
        rd_lit(5'h04, 32'h14, "R5");
        rd_lit(5'h10, 32'h3, "R1");

        // R3 / R4 drain and reuse
        cur_req = "R3";
        wr(5'h00, mk_ctrl(1, 0, 1, 0, 0, 0, 0));
        idle(3);
        rd_mod(5'h04, "R3");
        rd_lit(5'h0C, 32'h1, "R3");
        cur_req = "R4";
        idle(25);
        rd_lit(5'h04, 32'h10, "R4");
        rd_lit(5'h0C, 32'h4, "R4");

        // R9 period length by edge timing
        cur_req = "R9";
        wr(5'h0C, 32'h2);
        idle(8);
        t0 = -1; t1 = -1; prev = pwm_out;
        for (int c = 0; c < 30 && t1 < 0; c++) begin
            @(negedge clk);
            if (pwm_out && !prev) begin
                if (t0 < 0) t0 = c; else t1 = c;
            end
            prev = pwm_out;
        end
        check(t1 - t0, 32'd5, "R9");

        // R7 prescaler
        cur_req = "R7";
        wr(5'h00, mk_ctrl(1, 2, 1, 0, 0, 0, 0));
        wr(5'h0C, 32'h3);
        idle(40);
        rd_mod(5'h00, "R7");

        // R8 clock select
        cur_req = "R8";
        wr(5'h00, mk_ctrl(1, 0, 2, 0, 0, 0, 0));
        idle(30);
        wr(5'h00, mk_ctrl(1, 0, 0, 0, 0, 0, 0));
        idle(10);
        wr(5'h00, mk_ctrl(1, 0, 3, 0, 0, 0, 0));
        idle(6);

        // R10 comparison corners and inversion
        cur_req = "R10";
        wr(5'h00, mk_ctrl(1, 0, 1, 1, 0, 0, 0));
        wr(5'h0C, 32'h3);
        wr(5'h0C, 32'h0);
        wr(5'h0C, 32'h7);
        idle(20);
        wr(5'h00, mk_ctrl(1, 0, 1, 0, 0, 0, 0));
        idle(12);

        // R12 low-power freezes
        cur_req = "R12";
        wr(5'h0C, 32'h2);
        doze_req = 1'b1; idle(9);
        wr(5'h00, mk_ctrl(1, 0, 1, 0, 0, 0, 1)); idle(9);
        doze_req = 1'b0; wait_req = 1'b1; idle(9);
        wr(5'h00, mk_ctrl(1, 0, 1, 0, 0, 1, 0)); idle(9);
        wait_req = 1'b0; debug_req = 1'b1; idle(9);
        wr(5'h00, mk_ctrl(1, 0, 1, 0, 1, 0, 0)); idle(9);
        debug_req = 1'b0;

        // R11 disabled output level
        cur_req = "R11";
        wr(5'h00, mk_ctrl(0, 0, 1, 1, 0, 0, 0));
        idle(3);
        check({31'h0, pwm_out}, 32'h1, "R11");
        wr(5'h00, mk_ctrl(0, 0, 1, 0, 0, 0, 0));
        idle(2);
        check({31'h0, pwm_out}, 32'h0, "R11");

        // R6 soft reset
        cur_req = "R6";
        wr(5'h0C, 32'h1);
        wr(5'h0C, 32'h2);
        wr(5'h00, 32'h0000_0008);
        rd_lit(5'h00, 32'h8, "R6");
        wr(5'h10, 32'h7);
        idle(3);
        rd_lit(5'h00, 32'h0, "R6");
        rd_lit(5'h04, 32'h0, "R6");
        rd_lit(5'h10, 32'h0, "R6");
        rd_lit(5'h0C, 32'h0, "R6");

        // R1 full control field readback, reserved bit dropped
        cur_req = "R1";
        wr(5'h00, 32'h8000_0000 | mk_ctrl(0, 12'hABC, 2, 1, 1, 1, 1));
        rd_lit(5'h00, 32'h01C6_ABC0, "R1");
        rd_mod(5'h00, "R1");
        idle(2);

        running = 0;
        done = 1;
        summary();
        $finish;
    end
endmodule